// File: doc/BRIEF.md
# Queue-Condition Interrupt Controller

This block turns the status flags of a bank of hardware queues into two interrupt lines. Each queue reports four level flags: empty, nearly empty, nearly full and full. Each queue in the lower half of the bank has a three-bit source select. The select names one of the four flags and can invert it, so a queue can raise a request on any of eight conditions. Queues in the upper half have no select. They always raise a request when their nearly-empty flag is low.

A request is latched into a sticky pending bit, but only while that queue's enable bit is set. The pending bits form two 32-bit halves, and each half drives its own interrupt line. Software clears a pending bit by writing a one to it. Software reaches the source, enable and pending registers through a plain word-wide register port. The queue storage itself lies outside the block, and only its flags come in.

Top module: `qcond_irq_ctrl`

## Requirements
- R1: After reset, every source select, enable bit and pending bit is zero, both interrupt lines are low, and every register reads zero.
- R2: Queue q (0..31) has a 4-bit field at bits [4*(q%8)+3 : 4*(q%8)] of source register q/8 (addresses 0..3). Field bits [1:0] pick the flag: 0 empty, 1 nearly empty, 2 nearly full, 3 full. Field bit 3 is reserved, is not stored and reads 0.
- R3: Source field bit 2 inverts the picked flag, giving the not-empty, not-nearly-empty, not-nearly-full and not-full conditions.
- R4: Queues 32..63 raise a request exactly when their nearly-empty flag is low. Writes to the source registers do not change this.
- R5: A pending bit is set at a clock edge only when the queue's stored enable bit is 1 and its selected condition is true in that cycle. A disabled queue never sets its pending bit.
- R6: A pending bit stays set after its condition goes false, until software clears it.
- R7: Writing to a pending register (address 6 for queues 0..31, address 7 for queues 32..63, bit = q%32) clears each bit written as 1. Bits written as 0 are unchanged. Writing all ones clears the whole half. A write never sets a pending bit.
- R8: If a clear and a new request reach the same bit in the same cycle, the clear wins. A condition that is still true then sets the bit again at the following edge.
- R9: The low interrupt line is the OR of pending bits 0..31, and the high line is the OR of pending bits 32..63.
- R10: Clearing an enable bit leaves that queue's pending bit unchanged.
- R11: Enable registers sit at address 4 (queues 0..31) and address 5 (queues 32..63, bit = q%32), and read back what was written. Addresses 8..15 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| q_empty | input | 64 | Per-queue empty flag |
| q_near_empty | input | 64 | Per-queue nearly-empty flag |
| q_near_full | input | 64 | Per-queue nearly-full flag |
| q_full | input | 64 | Per-queue full flag |
| irq_lo | output | 1 | Interrupt for queues 0..31 |
| irq_hi | output | 1 | Interrupt for queues 32..63 |

## Verification
Two queues in different source registers are each tried with all eight select codes. For each code, only the picked flag is driven in one pass, and every flag except the picked one is driven in a second pass. This separates a wrong flag index, a missing inversion and a misplaced field. An upper-half queue is driven with the nearly-empty flag high and then low, after the source registers have been filled with ones, which shows that its source is fixed. Directed timing cases cover a condition that lasts after a clear, a condition that is dropped before a clear, a partial clear, a disable that leaves pending set, and a disabled queue whose condition is true. These show the clear-over-set priority, stickiness and enable gating cycle by cycle.

// File: rtl/qcond_irq_pkg.sv
package qcond_irq_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 4;
  localparam int SEL_W   = 3;
  localparam int FIELD_W = 4;

  localparam logic [ADDR_W-1:0] ADR_EN_LO   = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_EN_HI   = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_PEND_LO = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_PEND_HI = 4'd7;

  typedef enum logic [1:0] {
    FLG_EMPTY  = 2'd0,
    FLG_NEMPTY = 2'd1,
    FLG_NFULL  = 2'd2,
    FLG_FULL   = 2'd3
  } flag_idx_e;

  typedef struct packed {
    logic      invert;
    flag_idx_e idx;
  } src_sel_t;
endpackage

// File: rtl/qcond_cond_sel.sv
module qcond_cond_sel
  import qcond_irq_pkg::*;
#(
  parameter int NUM_Q = 64
) (
  input  src_sel_t [NUM_Q/2-1:0] src_sel,
  input  logic [NUM_Q-1:0]       q_empty,
  input  logic [NUM_Q-1:0]       q_near_empty,
  input  logic [NUM_Q-1:0]       q_near_full,
  input  logic [NUM_Q-1:0]       q_full,
  output logic [NUM_Q-1:0]       cond
);
  localparam int HALF = NUM_Q / 2;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    if (q < HALF) begin : g_sel
      logic picked;
      always_comb begin
        case (src_sel[q].idx)
          FLG_EMPTY:  picked = q_empty[q];
          FLG_NEMPTY: picked = q_near_empty[q];
          FLG_NFULL:  picked = q_near_full[q];
          default:    picked = q_full[q];
        endcase
        cond[q] = picked ^ src_sel[q].invert;
      end
    end else begin : g_fixed
      assign cond[q] = ~q_near_empty[q];
    end
  end
endmodule

// File: rtl/qcond_regfile.sv
module qcond_regfile
  import qcond_irq_pkg::*;
#(
  parameter int NUM_Q = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wen,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [REG_W-1:0]        reg_wdata,
  output logic [REG_W-1:0]        reg_rdata,
  input  logic [NUM_Q-1:0]        pend,
  output src_sel_t [NUM_Q/2-1:0]  src_sel,
  output logic [NUM_Q-1:0]        enable,
  output logic [NUM_Q-1:0]        pend_clr
);
  localparam int HALF     = NUM_Q / 2;
  localparam int PER_REG  = REG_W / FIELD_W;
  localparam int NUM_SRC  = HALF / PER_REG;

  src_sel_t [HALF-1:0]  src_q, src_d;
  logic [NUM_Q-1:0]     en_q, en_d;
  logic                 src_we, en_we;

  always_comb begin
    src_d  = src_q;
    src_we = 1'b0;
    for (int r = 0; r < NUM_SRC; r++) begin
      if (reg_wen && reg_addr == ADDR_W'(r)) begin
        src_we = 1'b1;
        for (int k = 0; k < PER_REG; k++)
          src_d[r*PER_REG+k] = src_sel_t'(reg_wdata[k*FIELD_W +: SEL_W]);
      end
    end
  end

  always_comb begin
    en_d  = en_q;
    en_we = 1'b0;
    if (reg_wen && reg_addr == ADR_EN_LO) begin
      en_d[HALF-1:0] = reg_wdata[HALF-1:0];
      en_we = 1'b1;
    end
    if (reg_wen && reg_addr == ADR_EN_HI) begin
      en_d[NUM_Q-1:HALF] = reg_wdata[HALF-1:0];
      en_we = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       src_q <= '0;
    else if (src_we)  src_q <= src_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (en_we)  en_q <= en_d;
  end

  always_comb begin
    pend_clr = '0;
    if (reg_wen && reg_addr == ADR_PEND_LO) pend_clr[HALF-1:0]     = reg_wdata[HALF-1:0];
    if (reg_wen && reg_addr == ADR_PEND_HI) pend_clr[NUM_Q-1:HALF] = reg_wdata[HALF-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    for (int r = 0; r < NUM_SRC; r++) begin
      if (reg_addr == ADDR_W'(r)) begin
        for (int k = 0; k < PER_REG; k++)
          reg_rdata[k*FIELD_W +: SEL_W] = src_q[r*PER_REG+k];
      end
    end
    case (reg_addr)
      ADR_EN_LO:   reg_rdata = REG_W'(en_q[HALF-1:0]);
      ADR_EN_HI:   reg_rdata = REG_W'(en_q[NUM_Q-1:HALF]);
      ADR_PEND_LO: reg_rdata = REG_W'(pend[HALF-1:0]);
      ADR_PEND_HI: reg_rdata = REG_W'(pend[NUM_Q-1:HALF]);
      default: ;
    endcase
  end

  assign src_sel = src_q;
  assign enable  = en_q;
endmodule

// File: rtl/qcond_pending.sv
module qcond_pending #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_req,
  input  logic [W-1:0] clr_req,
  output logic [W-1:0] pend,
  output logic         any
);
  logic [W-1:0] pend_q, pend_d;
  logic         upd;

  always_comb begin
    pend_d = (pend_q | set_req) & ~clr_req;
    upd    = |(set_req | clr_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend_q <= '0;
    else if (upd)  pend_q <= pend_d;
  end

  assign pend = pend_q;
  assign any  = |pend_q;
endmodule

// File: rtl/qcond_irq_ctrl.sv
module qcond_irq_ctrl
  import qcond_irq_pkg::*;
#(
  parameter int NUM_Q = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_Q-1:0]  q_empty,
  input  logic [NUM_Q-1:0]  q_near_empty,
  input  logic [NUM_Q-1:0]  q_near_full,
  input  logic [NUM_Q-1:0]  q_full,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int HALF = NUM_Q / 2;

  logic [1:0]            rst_pipe;
  logic                  rst_sync_n;
  src_sel_t [HALF-1:0]   src_sel;
  logic [NUM_Q-1:0]      enable, pend_clr, cond, pend, set_req;
  logic [1:0]            half_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  qcond_regfile #(.NUM_Q(NUM_Q)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_wen   (reg_wen),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pend      (pend),
    .src_sel   (src_sel),
    .enable    (enable),
    .pend_clr  (pend_clr)
  );

  qcond_cond_sel #(.NUM_Q(NUM_Q)) u_cond (
    .src_sel      (src_sel),
    .q_empty      (q_empty),
    .q_near_empty (q_near_empty),
    .q_near_full  (q_near_full),
    .q_full       (q_full),
    .cond         (cond)
  );

  assign set_req = cond & enable;

  for (genvar h = 0; h < 2; h++) begin : g_half
    qcond_pending #(.W(HALF)) u_pend (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .set_req (set_req[h*HALF +: HALF]),
      .clr_req (pend_clr[h*HALF +: HALF]),
      .pend    (pend[h*HALF +: HALF]),
      .any     (half_any[h])
    );
  end

  assign irq_lo = half_any[0];
  assign irq_hi = half_any[1];
endmodule

// File: rtl/qcond_irq_chk.sv
module qcond_irq_chk #(
  parameter int NUM_Q = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wen,
  input logic [3:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [NUM_Q-1:0] q_near_empty,
  input logic [NUM_Q-1:0] enable,
  input logic [NUM_Q-1:0] cond,
  input logic [NUM_Q-1:0] pend,
  input logic             irq_lo,
  input logic             irq_hi
);
  localparam int HALF = NUM_Q / 2;
  logic [NUM_Q-1:0] wr_clr;

  always_comb begin
    wr_clr = '0;
    if (reg_wen && reg_addr == 4'd6) wr_clr[HALF-1:0]     = reg_wdata[HALF-1:0];
    if (reg_wen && reg_addr == 4'd7) wr_clr[NUM_Q-1:HALF] = reg_wdata[HALF-1:0];
  end

  // R5
  pend_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) & ~$past(enable & cond)) == '0);

  // R6
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend) & ~pend & ~$past(wr_clr)) == '0);

  // R7
  pend_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & $past(wr_clr)) == '0);

  // R4
  hi_src_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend[NUM_Q-1:HALF] & ~$past(pend[NUM_Q-1:HALF])) & $past(q_near_empty[NUM_Q-1:HALF])) == '0);

  // R9
  irq_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo == (pend[HALF-1:0] != '0)) && (irq_hi == (pend[NUM_Q-1:HALF] != '0)));
endmodule

bind qcond_irq_ctrl qcond_irq_chk #(.NUM_Q(NUM_Q)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .reg_wen      (reg_wen),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .q_near_empty (q_near_empty),
  .enable       (enable),
  .cond         (cond),
  .pend         (pend),
  .irq_lo       (irq_lo),
  .irq_hi       (irq_hi)
);

// File: tb/qcond_irq_ctrl_tb.sv
`timescale 1ns/1ps
module qcond_irq_ctrl_tb;
  logic        clk;
  logic        rst_n;
  logic        reg_wen;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [63:0] fe, fne, fnf, ff;
  logic        irq_lo, irq_hi;
  int          n_chk, n_bad;
  bit          done;

  qcond_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .q_empty(fe), .q_near_empty(fne), .q_near_full(fnf), .q_full(ff),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(4'd4, 32'h0); wr(4'd5, 32'h0);
    wr(4'd6, 32'hFFFF_FFFF); wr(4'd7, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      check($sformatf("R1 reg %0d after reset", a), d, 32'h0);
    end
    check("R1 irq lines after reset", {30'h0, irq_hi, irq_lo}, 32'h0);
  endtask

  task automatic t_src_select(input int q);
    logic [31:0] d;
    logic [3:0]  fl;
    bit          exp;
    for (int sel = 0; sel < 8; sel++) begin
      for (int pass = 0; pass < 2; pass++) begin
        quiesce();
        fl = (pass == 0) ? (4'b0001 << (sel % 4)) : ~(4'b0001 << (sel % 4));
        fe = '0; fne = '1; fnf = '0; ff = '0;
        fe[q] = fl[0]; fne[q] = fl[1]; fnf[q] = fl[2]; ff[q] = fl[3];
        wr(4'(q / 8), 32'(4'(sel) | 4'h8) << (4 * (q % 8)));
        rd(4'(q / 8), d);
        check($sformatf("R2 src readback q%0d sel%0d", q, sel), d, 32'(sel) << (4 * (q % 8)));
        wr(4'd4, 32'h1 << q);
        idle(2);
        exp = fl[sel % 4] ^ ((sel & 4) != 0);
        rd(4'd6, d);
        check($sformatf("R2 R3 pend q%0d sel%0d pass%0d", q, sel, pass), d, 32'(exp) << q);
      end
    end
    quiesce();
    wr(4'(q / 8), 32'h0);
  endtask

  task automatic t_upper_fixed();
    logic [31:0] d;
    quiesce();
    fe = '0; fnf = '0; ff = '0; fne = '1;
    for (int r = 0; r < 4; r++) wr(4'(r), 32'hFFFF_FFFF);
    wr(4'd5, 32'h1 << 8);
    idle(3);
    rd(4'd7, d);
    check("R4 q40 near-empty high no pend", d, 32'h0);
    fe[40] = 1'b1; ff[40] = 1'b1;
    idle(2);
    rd(4'd7, d);
    check("R4 q40 ignores other flags", d, 32'h0);
    fne[40] = 1'b0;
    idle(2);
    rd(4'd7, d);
    check("R4 q40 near-empty low sets pend", d, 32'h100);
    check("R9 irq_hi set, irq_lo clear", {30'h0, irq_hi, irq_lo}, 32'h2);
    fne[40] = 1'b1; fe = '0; ff = '0;
    quiesce();
    for (int r = 0; r < 4; r++) wr(4'(r), 32'h0);
    check("R9 irq lines low after clear", {30'h0, irq_hi, irq_lo}, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    quiesce();
    fne = '1; fe = '1;
    idle(3);
    rd(4'd6, d);
    check("R5 disabled queues never pend", d, 32'h0);
    check("R5 irq_lo low while disabled", {31'h0, irq_lo}, 32'h0);
    fe = '0;
  endtask

  task automatic t_sticky_and_w1c();
    logic [31:0] d;
    quiesce();
    fe = '0; fne = '1;
    fe[3] = 1'b1; fe[9] = 1'b1;
    wr(4'd4, 32'h208);
    idle(1);
    fe[3] = 1'b0; fe[9] = 1'b0;
    idle(2);
    rd(4'd6, d);
    check("R6 pend sticky after condition drops", d, 32'h208);
    wr(4'd6, 32'h8);
    rd(4'd6, d);
    check("R7 partial clear keeps other bit", d, 32'h200);
    wr(4'd6, 32'h0);
    rd(4'd6, d);
    check("R7 zero write no effect", d, 32'h200);
    wr(4'd6, 32'hFFFF_FFFF);
    rd(4'd6, d);
    check("R7 all-ones clears half", d, 32'h0);
    wr(4'd6, 32'h0000_0400);
    wr(4'd7, 32'h0000_0400);
    rd(4'd6, d);
    check("R7 write never sets lo", d, 32'h0);
    rd(4'd7, d);
    check("R7 write never sets hi", d, 32'h0);
    quiesce();
  endtask

  task automatic t_clear_race();
    logic [31:0] d;
    quiesce();
    fe = '0; fne = '1;
    fe[7] = 1'b1;
    wr(4'd4, 32'h80);
    idle(1);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = 4'd6; reg_wdata = 32'h80;
    @(negedge clk);
    reg_wen = 1'b0;
    rd(4'd6, d);
    check("R8 clear wins in its cycle", d, 32'h0);
    @(negedge clk);
    rd(4'd6, d);
    check("R8 still-true condition sets again next edge", d, 32'h80);
    check("R9 irq_lo follows pend", {31'h0, irq_lo}, 32'h1);
    fe[7] = 1'b0;
    quiesce();
  endtask

  task automatic t_enable_clear();
    logic [31:0] d;
    quiesce();
    fe = '0; fne = '1;
    fe[3] = 1'b1;
    wr(4'd4, 32'h8);
    idle(1);
    fe[3] = 1'b0;
    wr(4'd4, 32'h0);
    idle(1);
    rd(4'd6, d);
    check("R10 pend kept after disable", d, 32'h8);
    check("R10 irq_lo kept after disable", {31'h0, irq_lo}, 32'h1);
    quiesce();
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    quiesce();
    fne = '1; fe = '0; fnf = '0; ff = '0;
    wr(4'd4, 32'hA5A5_0F0F);
    wr(4'd5, 32'h1234_5678);
    rd(4'd4, d);
    check("R11 enable lo readback", d, 32'hA5A5_0F0F);
    rd(4'd5, d);
    check("R11 enable hi readback", d, 32'h1234_5678);
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd15, 32'hFFFF_FFFF);
    for (int a = 8; a < 16; a++) begin
      rd(4'(a), d);
      check($sformatf("R11 unused addr %0d reads zero", a), d, 32'h0);
    end
    rd(4'd4, d);
    check("R11 unused writes leave enable", d, 32'hA5A5_0F0F);
    quiesce();
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; reg_wen = 1'b0; reg_addr = '0; reg_wdata = '0;
    fe = '0; fne = '1; fnf = '0; ff = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_src_select(5);
    t_src_select(13);
    t_upper_fixed();
    t_disabled();
    t_sticky_and_w1c();
    t_clear_race();
    t_enable_clear();
    t_regmap();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule